// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Arbiter

This block gathers up to 53 level-sensitive interrupt request lines and decides which one is offered to the processor. Each line has an enable bit, a pending bit, an active bit and a 3-bit priority. Smaller priority values are more urgent. When two candidates have the same priority, the line with the lower number is chosen. The selected line number is driven on `irq_id`, qualified by `irq_valid`.

The processor drives `irq_ack` when its handler for the offered line starts. That moves the line from pending to active. When the handler finishes, the processor returns the line number on `cpl_id` with `cpl_valid`, and the active bit is cleared. A line is offered only if its priority is strictly more urgent than every line that is active at that moment, so handlers nest by priority.

A small word-addressed register port holds the enables and the priorities, and can read back the pending state. Register reads are combinational. Writes take effect at the next clock edge.

Top module: `prio_irq_arbiter`

## Requirements
- R1: After reset, all enable, pending and active bits are 0, every priority reads as 0, and `irq_valid` is 0.
- R2: A write to word 0 (lines 0..31) or word 1 (lines 32..63) sets the enable bit of every line whose data bit is 1. Data bits that are 0 leave enables unchanged, and bits for line numbers of 53 or more are ignored. Reading word 0 or 1 returns the enables, with bit k of word w standing for line 32w+k.
- R3: A write to word 2 or word 3 clears the enable bit of every line whose data bit is 1, using the same bit mapping as R2. Data bits that are 0 have no effect. Reads of words 2 and 3 also return the enables.
- R4: Line n has a priority byte at word 8+n/4, in byte lane n%4 (bits 8*(n%4)+7 down to 8*(n%4)). That lane is written only when `reg_be[n%4]` is 1. Only the top 3 bits of the byte are stored, so the lower 5 bits read back as 0; for example, writing 0xC0 stores level 6.
- R5: On a clock edge where a line's request is high and the line is not active, its pending bit is set, whatever the enable. Pending bits can be read at word 4 (lines 0..31) and word 5 (lines 32..63). Writes to these words have no effect.
- R6: `irq_valid` is 1 when at least one line is both pending and enabled and the best such line passes the R7 rule. `irq_id` is the pending, enabled line with the smallest priority value; ties go to the lowest line number.
- R7: A candidate is offered only if its priority value is strictly smaller than the priority value of every active line. A candidate whose priority equals that of an active line stays blocked.
- R8: On a clock edge where `irq_ack` and `irq_valid` are both 1, the offered line's pending bit is cleared and its active bit is set. When `irq_valid` is 0, `irq_ack` is ignored.
- R9: On a clock edge where `cpl_valid` is 1, the active bit of line `cpl_id` is cleared. If that line's request is still high, the line becomes pending again on the following edge and is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 53 | Level-sensitive request per line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte enables; used by priority writes |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_valid | output | 1 | A line is being offered |
| irq_id | output | 6 | Number of the offered line |
| irq_ack | input | 1 | Handler start for the offered line |
| cpl_valid | input | 1 | Handler completion strobe |
| cpl_id | input | 6 | Number of the line whose handler completed |

## Verification
A request that is driven high becomes visible in the pending read-back, and in `irq_valid`/`irq_id`, after one rising edge. The effects of acknowledge, completion and register writes also appear one edge after the edge that samples them, because the offer is computed combinationally from the registered state. After a completion, a request that is still held needs a second edge before it becomes pending again. The bench changes inputs on the falling edge. It compares outputs at the next falling edge, which is after exactly one rising edge, against a cycle-level model of the requirements. Register reads are compared a short delay after the address is set, without waiting for a clock edge.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
    // Register port geometry.
    localparam int REG_DW  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = REG_DW / LANE_W;
    localparam int MAX_IRQ = 2 * REG_DW;

    // Word offsets of the register banks; each bit bank spans two words.
    localparam int OFS_EN_SET = 0;
    localparam int OFS_EN_CLR = 2;
    localparam int OFS_PEND   = 4;
    localparam int OFS_PRIO   = 8;
endpackage

// File: rtl/prio_arb_regs.sv
module prio_arb_regs
    import prio_arb_pkg::*;
#(
    parameter int NUM_IRQ   = 53,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic [ADDR_W-1:0]                  reg_addr,
    input  logic [REG_DW-1:0]                  reg_wdata,
    input  logic [LANES-1:0]                   reg_be,
    input  logic [NUM_IRQ-1:0]                 pend_i,
    output logic [REG_DW-1:0]                  reg_rdata,
    output logic [NUM_IRQ-1:0]                 en_o,
    output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio_o
);
    localparam int PRIO_WORDS = (NUM_IRQ + LANES - 1) / LANES;
    localparam int PRIO_LSB   = LANE_W - PRIO_BITS;

    typedef struct packed {
        logic [NUM_IRQ-1:0]                en;
        logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
    } regs_t;

    regs_t r_d, r_q;

    logic              sel_half;
    logic              hit_set, hit_clr, hit_pend, hit_prio;
    logic [ADDR_W-1:0] prio_word;

    // Address decode shared by the write and read paths.
    always_comb begin
        sel_half  = reg_addr[0];
        hit_set   = reg_addr[ADDR_W-1:1] == (ADDR_W-1)'(OFS_EN_SET / 2);
        hit_clr   = reg_addr[ADDR_W-1:1] == (ADDR_W-1)'(OFS_EN_CLR / 2);
        hit_pend  = reg_addr[ADDR_W-1:1] == (ADDR_W-1)'(OFS_PEND / 2);
        hit_prio  = (reg_addr >= ADDR_W'(OFS_PRIO)) &&
                    (reg_addr <  ADDR_W'(OFS_PRIO + PRIO_WORDS));
        prio_word = reg_addr - ADDR_W'(OFS_PRIO);
    end

    // Next state: write-one-to-set and write-one-to-clear enables, byte-lane priorities.
    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (reg_wr && (i / REG_DW == int'(sel_half)) && reg_wdata[i % REG_DW]) begin
                if (hit_set) r_d.en[i] = 1'b1;
                if (hit_clr) r_d.en[i] = 1'b0;
            end
            if (reg_wr && hit_prio && (i / LANES == int'(prio_word)) && reg_be[i % LANES]) begin
                r_d.prio[i] = reg_wdata[(i % LANES) * LANE_W + PRIO_LSB +: PRIO_BITS];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if ((hit_set || hit_clr) && (i / REG_DW == int'(sel_half)))
                reg_rdata[i % REG_DW] = r_q.en[i];
            if (hit_pend && (i / REG_DW == int'(sel_half)))
                reg_rdata[i % REG_DW] = pend_i[i];
            if (hit_prio && (i / LANES == int'(prio_word)))
                reg_rdata[(i % LANES) * LANE_W + PRIO_LSB +: PRIO_BITS] = r_q.prio[i];
        end
    end

    assign en_o   = r_q.en;
    assign prio_o = r_q.prio;
endmodule

// File: rtl/prio_arb_state.sv
module prio_arb_state #(
    parameter int NUM_IRQ = 53,
    parameter int ID_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] req_i,
    input  logic               take_i,
    input  logic [ID_W-1:0]    take_id_i,
    input  logic               done_i,
    input  logic [ID_W-1:0]    done_id_i,
    output logic [NUM_IRQ-1:0] pend_o,
    output logic [NUM_IRQ-1:0] act_o
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] pend;
        logic [NUM_IRQ-1:0] act;
    } state_t;

    state_t s_d, s_q;

    // A request latches into pending unless its line is in service.
    // Taking a line moves it from pending to active in one edge.
    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            logic take_me;
            logic done_me;
            take_me = take_i && (take_id_i == ID_W'(i));
            done_me = done_i && (done_id_i == ID_W'(i));
            s_d.pend[i] = (s_q.pend[i] | (req_i[i] & ~s_q.act[i])) & ~take_me;
            s_d.act[i]  = take_me | (s_q.act[i] & ~done_me);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;
    assign act_o  = s_q.act;
endmodule

// File: rtl/prio_arb_pick.sv
module prio_arb_pick #(
    parameter int NUM_IRQ   = 53,
    parameter int PRIO_BITS = 3,
    parameter int ID_W      = 6
) (
    input  logic [NUM_IRQ-1:0]                 cand_i,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio_i,
    output logic                               found_o,
    output logic [ID_W-1:0]                    id_o,
    output logic [PRIO_BITS-1:0]               lvl_o
);
    // Ascending scan; a strict compare keeps the lower number on equal levels.
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        lvl_o   = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand_i[i] && (!found_o || (prio_i[i] < lvl_o))) begin
                found_o = 1'b1;
                id_o    = ID_W'(i);
                lvl_o   = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/prio_arb_ceiling.sv
module prio_arb_ceiling #(
    parameter int NUM_IRQ   = 53,
    parameter int PRIO_BITS = 3
) (
    input  logic [NUM_IRQ-1:0]                 act_i,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio_i,
    output logic                               any_o,
    output logic [PRIO_BITS-1:0]               lvl_o
);
    // Most urgent level among lines in service.
    always_comb begin
        any_o = |act_i;
        lvl_o = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (act_i[i] && (prio_i[i] < lvl_o)) lvl_o = prio_i[i];
        end
    end
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
    import prio_arb_pkg::*;
#(
    parameter int NUM_IRQ   = 53,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 5,
    localparam int ID_W     = $clog2(NUM_IRQ)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_req,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    input  logic [LANES-1:0]    reg_be,
    output logic [REG_DW-1:0]   reg_rdata,
    output logic                irq_valid,
    output logic [ID_W-1:0]     irq_id,
    input  logic                irq_ack,
    input  logic                cpl_valid,
    input  logic [ID_W-1:0]     cpl_id
);
    logic [NUM_IRQ-1:0]                en_vec;
    logic [NUM_IRQ-1:0]                pend_vec;
    logic [NUM_IRQ-1:0]                act_vec;
    logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_vec;

    logic                 win_found;
    logic [ID_W-1:0]      win_id;
    logic [PRIO_BITS-1:0] win_lvl;
    logic                 ceil_any;
    logic [PRIO_BITS-1:0] ceil_lvl;
    logic                 take;

    prio_arb_regs #(
        .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
        .pend_i(pend_vec), .reg_rdata(reg_rdata),
        .en_o(en_vec), .prio_o(prio_vec)
    );

    prio_arb_state #(
        .NUM_IRQ(NUM_IRQ), .ID_W(ID_W)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .req_i(irq_req),
        .take_i(take), .take_id_i(irq_id),
        .done_i(cpl_valid), .done_id_i(cpl_id),
        .pend_o(pend_vec), .act_o(act_vec)
    );

    prio_arb_pick #(
        .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)
    ) u_pick (
        .cand_i(pend_vec & en_vec), .prio_i(prio_vec),
        .found_o(win_found), .id_o(win_id), .lvl_o(win_lvl)
    );

    prio_arb_ceiling #(
        .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)
    ) u_ceiling (
        .act_i(act_vec), .prio_i(prio_vec),
        .any_o(ceil_any), .lvl_o(ceil_lvl)
    );

    // Offer only a candidate strictly more urgent than everything in service.
    assign irq_valid = win_found && (!ceil_any || (win_lvl < ceil_lvl));
    assign irq_id    = win_id;
    assign take      = irq_ack && irq_valid;
endmodule

// File: rtl/prio_arb_checker.sv
module prio_arb_checker #(
    parameter int NUM_IRQ   = 53,
    parameter int PRIO_BITS = 3,
    parameter int ID_W      = 6
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               irq_valid,
    input logic [ID_W-1:0]                    irq_id,
    input logic                               irq_ack,
    input logic                               cpl_valid,
    input logic [ID_W-1:0]                    cpl_id,
    input logic                               reg_wr,
    input logic [NUM_IRQ-1:0]                 en,
    input logic [NUM_IRQ-1:0]                 pend,
    input logic [NUM_IRQ-1:0]                 act,
    input logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio
);
    logic beats_all;

    always_comb begin
        beats_all = 1'b1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (act[i] && !(prio[irq_id] < prio[i])) beats_all = 1'b0;
        end
    end

    AST_OFFER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (int'(irq_id) < NUM_IRQ)); // R6
    AST_OFFER_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (pend[irq_id] && en[irq_id])); // R6
    AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> beats_all); // R7
    AST_PEND_ACT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & act) == '0); // R5
    AST_ACK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack) |=> (act[$past(irq_id)] && !pend[$past(irq_id)])); // R8
    AST_ACT_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_valid && irq_ack) |=> ((act & ~$past(act)) == '0)); // R8
    AST_CPL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !(irq_valid && irq_ack && irq_id == cpl_id)) |=> !act[$past(cpl_id)]); // R9
    AST_EN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(en)); // R2
endmodule

bind prio_irq_arbiter prio_arb_checker #(
    .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)
) i_checker (
    .clk(clk), .rst_n(rst_n),
    .irq_valid(irq_valid), .irq_id(irq_id), .irq_ack(irq_ack),
    .cpl_valid(cpl_valid), .cpl_id(cpl_id), .reg_wr(reg_wr),
    .en(en_vec), .pend(pend_vec), .act(act_vec), .prio(prio_vec)
);

// File: tb/test_prio_irq_arbiter.sv
`timescale 1ns/1ps
module test_prio_irq_arbiter;
    localparam int N  = 53;
    localparam int PB = 3;
    localparam int AW = 5;
    localparam int IW = 6;
    localparam logic [63:0] LINE_MASK = (64'd1 << N) - 64'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req;
    logic          reg_wr;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata;
    logic [3:0]    reg_be;
    logic [31:0]   reg_rdata;
    logic          irq_valid;
    logic [IW-1:0] irq_id;
    logic          irq_ack;
    logic          cpl_valid;
    logic [IW-1:0] cpl_id;

    always #2.5 clk = ~clk;

    prio_irq_arbiter #(.NUM_IRQ(N), .PRIO_BITS(PB), .ADDR_W(AW)) i_prio_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_req(req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
        .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_id(irq_id),
        .irq_ack(irq_ack), .cpl_valid(cpl_valid), .cpl_id(cpl_id)
    );

    // Reference model of the requirements.
    logic [63:0] m_en, m_pend, m_act;
    int          m_prio [N];
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input longint a, input longint e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    function automatic void pick(output bit f, output int w);
        int thr;
        int bp;
        thr = 8;
        bp  = 99;
        w   = 0;
        for (int i = 0; i < N; i++)
            if (m_act[i] && m_prio[i] < thr) thr = m_prio[i];
        for (int i = 0; i < N; i++)
            if (m_pend[i] && m_en[i] && m_prio[i] < bp) begin bp = m_prio[i]; w = i; end
        f = (bp < thr);
        if (!f) w = 0;
    endfunction

    function automatic logic [31:0] prio_word(input int w);
        logic [31:0] d;
        d = '0;
        for (int l = 0; l < 4; l++)
            if (4 * w + l < N) d[l*8+5 +: 3] = 3'(m_prio[4*w+l]);
        return d;
    endfunction

    // One clock: model update mirrors R2..R9, then wait for the next falling edge.
    task automatic step();
        bit f;
        int w;
        int a;
        logic [63:0] np, na, dv;
        pick(f, w);
        np = m_pend;
        na = m_act;
        for (int i = 0; i < N; i++) begin
            bit tk;
            bit dr;
            tk = irq_ack && f && (w == i);
            dr = cpl_valid && (int'(cpl_id) == i);
            np[i] = (m_pend[i] | (req[i] & ~m_act[i])) & ~tk;
            na[i] = tk | (m_act[i] & ~dr);
        end
        if (reg_wr) begin
            a  = int'(reg_addr);
            dv = reg_addr[0] ? {reg_wdata, 32'h0} : {32'h0, reg_wdata};
            if (a <= 1) m_en = (m_en | dv) & LINE_MASK;
            else if (a <= 3) m_en = m_en & ~dv;
            else if (a >= 8 && a < 22) begin
                for (int l = 0; l < 4; l++)
                    if ((a - 8) * 4 + l < N && reg_be[l]) m_prio[(a-8)*4+l] = int'(reg_wdata[l*8+5 +: 3]);
            end
        end
        @(negedge clk);
        m_pend = np;
        m_act  = na;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d; reg_be = be;
        step();
        reg_wr = 1'b0; reg_wdata = '0; reg_be = '0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string tag);
        reg_addr = AW'(a);
        #0.5;
        chk(reg_rdata === e, tag, longint'(reg_rdata), longint'(e));
    endtask

    task automatic check_out(input string tag);
        bit f;
        int w;
        pick(f, w);
        chk(irq_valid === f && (!f || int'(irq_id) == w), tag,
            irq_valid ? longint'(irq_id) : -1, f ? longint'(w) : -1);
    endtask

    task automatic expect_id(input int id, input string tag);
        chk(irq_valid === 1'b1 && int'(irq_id) == id, tag,
            irq_valid ? longint'(irq_id) : -1, longint'(id));
    endtask

    task automatic expect_none(input string tag);
        chk(irq_valid === 1'b0, tag, longint'(irq_valid), 0);
    endtask

    // Acknowledge and complete every offer until nothing is offered.
    task automatic drain();
        for (int k = 0; k < 60; k++) begin
            logic [IW-1:0] sid;
            if (irq_valid) begin
                check_out("R8 drain offer");
                sid = irq_id;
                irq_ack = 1'b1; step(); irq_ack = 1'b0;
                cpl_valid = 1'b1; cpl_id = sid; step(); cpl_valid = 1'b0;
            end
        end
        check_out("R9 drained");
    endtask

    task automatic set_pattern(input int mul, input int add);
        for (int w = 0; w < 14; w++) begin
            logic [31:0] d;
            d = 32'h1F1F_1F1F;
            for (int l = 0; l < 4; l++) d[l*8+5 +: 3] = 3'(((4*w + l) * mul + add) % 8);
            wr(8 + w, d, 4'hF);
        end
    endtask

    initial begin
        req = '0; reg_wr = 0; reg_addr = '0; reg_wdata = '0; reg_be = '0;
        irq_ack = 0; cpl_valid = 0; cpl_id = '0;
        m_en = '0; m_pend = '0; m_act = '0;
        for (int i = 0; i < N; i++) m_prio[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        expect_none("R1 no offer");
        for (int a = 0; a < 6; a++) rd(a, 32'h0, "R1 bit banks");
        for (int w = 0; w < 14; w++) rd(8 + w, 32'h0, "R1 priorities");

        // R2 zero writes and out-of-range bits
        wr(0, 32'h0, 4'hF);          rd(0, 32'h0, "R2 zero write");
        wr(1, 32'hFFE0_0000, 4'hF);  rd(1, 32'h0, "R2 bits beyond lines");
        for (int i = 0; i < N; i++) begin
            wr(i / 32, 32'd1 << (i % 32), 4'hF);
            rd(i / 32, m_en[(i/32)*32 +: 32], "R2 set sweep");
        end
        rd(1, 32'h001F_FFFF, "R2 all set word1");
        rd(2, 32'hFFFF_FFFF, "R3 clear bank reads enables");

        // R3 clear
        wr(2, 32'h0000_F0F0, 4'hF);
        rd(0, 32'hFFFF_0F0F, "R3 clear word0");
        wr(3, 32'h0010_0001, 4'hF);
        rd(3, 32'h000F_FFFE, "R3 clear word1");
        wr(2, 32'h0, 4'hF);
        rd(0, 32'hFFFF_0F0F, "R3 zero clear");
        wr(0, 32'hFFFF_FFFF, 4'hF);
        wr(1, 32'hFFFF_FFFF, 4'hF);

        // R4 priority bytes
        for (int w = 0; w < 14; w++) begin
            logic [31:0] d;
            d = 32'h9E37_79B9 * (w + 1);
            wr(8 + w, d, 4'hF);
            rd(8 + w, prio_word(w), "R4 byte store");
        end
        wr(8 + 13, 32'hFFFF_FFFF, 4'hF);
        rd(8 + 13, 32'h0000_00E0, "R4 last word lanes");
        wr(8 + 3, 32'hFFFF_FFFF, 4'b0100);
        rd(8 + 3, prio_word(3), "R4 byte enable");
        wr(8 + 4, 32'h0000_00C0, 4'b0001);
        chk(m_prio[16] == 6, "R4 0xC0 model", m_prio[16], 6);
        rd(8 + 4, prio_word(4), "R4 0xC0 level 6");
        set_pattern(5, 3);
        rd(8 + 1, prio_word(1), "R4 pattern");

        // R5/R6/R8/R9 single-line sweep
        for (int i = 0; i < N; i++) begin
            req = '0; req[i] = 1'b1;
            step();
            expect_id(i, "R6 single line");
            rd(4 + i / 32, 32'd1 << (i % 32), "R5 pending read");
            irq_ack = 1'b1; req = '0;
            step();
            irq_ack = 1'b0;
            expect_none("R8 taken");
            rd(4 + i / 32, 32'h0, "R8 pending cleared");
            cpl_valid = 1'b1; cpl_id = IW'(i);
            step();
            cpl_valid = 1'b0;
            check_out("R9 completed");
        end

        // R9 request held through service
        req = '0; req[20] = 1'b1;
        step();
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        expect_none("R9 in service");
        rd(4, 32'h0, "R5 no pend while active");
        cpl_valid = 1'b1; cpl_id = 6'd20; step(); cpl_valid = 1'b0;
        expect_none("R9 one edge after completion");
        step();
        expect_id(20, "R9 re-pend");
        irq_ack = 1'b1; req = '0; step(); irq_ack = 1'b0;
        cpl_valid = 1'b1; cpl_id = 6'd20; step(); cpl_valid = 1'b0;
        check_out("R9 released");

        // R5 pending regardless of enable
        wr(2, 32'hFFFF_FFFF, 4'hF);
        wr(3, 32'hFFFF_FFFF, 4'hF);
        req = '0; req[5] = 1'b1; req[17] = 1'b1; req[40] = 1'b1;
        step();
        req = '0;
        rd(4, 32'h0002_0020, "R5 pending disabled word0");
        rd(5, 32'h0000_0100, "R5 pending disabled word1");
        wr(4, 32'h0, 4'hF);
        rd(4, 32'h0002_0020, "R5 pending write ignored");
        expect_none("R6 disabled not offered");
        wr(1, 32'h0000_0100, 4'hF);
        expect_id(40, "R6 only enabled line");
        wr(0, 32'hFFFF_FFFF, 4'hF);
        wr(1, 32'hFFFF_FFFF, 4'hF);
        expect_id(17, "R6 most urgent level");
        drain();

        // R6 ties at one level
        set_pattern(0, 2);
        req = '0; req[45] = 1'b1; req[30] = 1'b1; req[12] = 1'b1;
        step();
        req = '0;
        expect_id(12, "R6 tie lowest number");
        drain();

        // R7 nesting: levels 5->4, 7->6, 13->4, 3->2
        set_pattern(5, 3);
        req = '0; req[5] = 1'b1; step();
        expect_id(5, "R7 first");
        irq_ack = 1'b1; req = '0; step(); irq_ack = 1'b0;
        req[7] = 1'b1; req[13] = 1'b1; step(); req = '0;
        expect_none("R7 equal or lower blocked");
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        expect_none("R8 stray ack ignored");
        rd(4, 32'h0000_2080, "R8 stray ack keeps pending");
        req[3] = 1'b1; step();
        expect_id(3, "R7 preempt");
        irq_ack = 1'b1; req = '0; step(); irq_ack = 1'b0;
        cpl_valid = 1'b1; cpl_id = 6'd3; step(); cpl_valid = 1'b0;
        expect_none("R7 still nested");
        cpl_valid = 1'b1; cpl_id = 6'd5; step(); cpl_valid = 1'b0;
        expect_id(13, "R7 after release");
        drain();

        // Mixed traffic against the model
        begin
            logic [31:0] lf;
            lf = 32'hACE1_2468;
            for (int c = 0; c < 800; c++) begin
                logic [63:0] x, y, r;
                int ub;
                int ui;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                x = {lf, lf ^ 32'h5A5A_5A5A};
                y = {x[31:0], x[63:32]};
                r = x & y & {y[15:0], y[63:16]};
                req = r[N-1:0];
                check_out("R7 mixed traffic");
                irq_ack = irq_valid && lf[3];
                ub = 99; ui = 0;
                for (int i = 0; i < N; i++)
                    if (m_act[i] && m_prio[i] < ub) begin ub = m_prio[i]; ui = i; end
                cpl_valid = (m_act != 0) && (lf[7:5] == 3'd0 || lf[9:8] == 2'd3);
                cpl_id = IW'(ui);
                step();
                irq_ack = 1'b0; cpl_valid = 1'b0;
                check_out("R8 mixed after edge");
            end
            req = '0;
            step();
            drain();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule